// File: doc/BRIEF.md
# Super-Pixel Column Readout with Token Arbitration

This block handles the readout of one pixel column. The column is built from several super pixels, and each super pixel groups eight pixels in a 4×2 block. Inside a super pixel, a token picks one of the pixels that hold a hit. The picked pixel's event is copied into a two-entry local queue, and the pixel is told through a one-cycle take pulse that its hit has been collected. The super pixels share a narrow column bus. One super pixel at a time sends the event at the head of its queue over this bus as a short burst of words, with a DataPresent line raised for the burst. A three-bit word counter in the super pixel tracks the burst.

At the end of the column, a receive buffer puts the words back together into the full event. It tags the event with the sending super pixel's address and keeps up to four events for the downstream reader. A new burst may start only when this buffer has room. Once a burst has started it always runs to its last word, so no event is ever split and none is lost.

Top module: `sp_column_readout`

## Requirements
- R1: Within a super pixel, the lowest-index pixel with its hit line high is taken first. At most one pixel per super pixel receives a take pulse in a cycle, and the pulse is in the same cycle as the hit it collects.
- R2: A hit is taken only while `shutter_i` is high and the super pixel's two-entry queue has a free slot. A hit that is not taken stays pending and gets no take pulse.
- R3: At most one super pixel drives the column bus at a time. When the bus is idle, the lowest-index super pixel with a stored event that is not yet sending wins. `col_addr_o` shows the sender's index while `col_valid_o` is high.
- R4: An event is stored as pixel data in bits [11:0] and the pixel index in bits [14:12], zero-padded to 15 bits. It is sent as 3 five-bit words in consecutive cycles, word k being bits [5k+4:5k], with `col_valid_o` high for those cycles. After the last word, the bus is idle for at least one cycle.
- R5: A burst starts only in the cycle after one in which `eoc_full_o` is low. The end-of-column buffer therefore never overflows. Readout waits while the buffer is full and resumes after a read frees an entry.
- R6: The end-of-column buffer holds 4 events of {super-pixel address [16:15], pixel index [14:12], data [11:0]} in arrival order. `eoc_valid_o` is high when it is not empty. `eoc_rd_i` removes the head at the clock edge, and a read while empty is ignored. `eoc_full_o` is high when 4 events are held.
- R7: After reset, all queues are empty and every output is low.
- R8: Events from one super pixel leave in the order they were taken, not in pixel-index order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutter_i | input | 1 | Enables taking hits from pixels |
| pix_hit_i | input | NUM_SP*PIX_PER_SP | Hit-ready line per pixel, index s*8+p |
| pix_data_i | input | NUM_SP*PIX_PER_SP*PIX_DW | Event data per pixel, pixel i at bits [i*12 +: 12] |
| pix_take_o | output | NUM_SP*PIX_PER_SP | One-cycle take pulse per pixel |
| col_data_o | output | BUS_W | Column bus word |
| col_valid_o | output | 1 | DataPresent: a word is on the bus |
| col_addr_o | output | SP_ADDR_W | Index of the sending super pixel |
| eoc_full_o | output | 1 | End-of-column buffer full |
| eoc_valid_o | output | 1 | End-of-column buffer holds an event |
| eoc_event_o | output | SP_ADDR_W+3+PIX_DW | Head event of the end-of-column buffer |
| eoc_rd_i | input | 1 | Remove the head event |

## Verification
Take pulses are combinational, so they appear in the same cycle as the hit they collect. Take a hit collected at the edge that ends cycle c. The bus grant is decided in cycle c+1, and words 0 to 2 appear in cycles c+2 to c+4. The event becomes readable in cycle c+5, and a read removes it at the next edge. The bench steps a behavioural queue model once per clock. It compares every output one time unit after the falling edge, once the inputs for that cycle have settled, so each result is checked in exactly the cycle it is due. Directed checks at the end of each scenario then confirm ordering, gating and full-buffer stalls.

// File: rtl/colro_pkg.sv
package colro_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int width_of(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/colro_sp_cell.sv
module colro_sp_cell
    import colro_pkg::*;
#(
    parameter int PIX_N  = 8,
    parameter int PIX_DW = 12,
    parameter int BUS_W  = 5,
    parameter int DEPTH  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shutter_i,
    input  logic [PIX_N-1:0]        hit_i,
    input  logic [PIX_N*PIX_DW-1:0] data_i,
    output logic [PIX_N-1:0]        take_o,
    input  logic                    start_i,
    output logic                    req_o,
    output logic                    sending_o,
    output logic [BUS_W-1:0]        word_o
);
    localparam int IDX_W  = width_of(PIX_N);
    localparam int EV_W   = IDX_W + PIX_DW;
    localparam int NWORDS = ceil_div(EV_W, BUS_W);
    localparam int PAD_W  = NWORDS * BUS_W;
    localparam int WCNT_W = 3;
    localparam int PTR_W  = width_of(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][EV_W-1:0] mem;
        logic [PTR_W-1:0]           wptr;
        logic [PTR_W-1:0]           rptr;
        logic [CNT_W-1:0]           cnt;
        tx_state_e                  tx;
        logic [WCNT_W-1:0]          wcnt;
    } cell_state_t;

    cell_state_t st_d, st_q;

    logic             any_hit;
    logic [IDX_W-1:0] pick;
    logic             capture;
    logic             last_word;
    logic [PAD_W-1:0] head_pad;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // token: the lowest-index pixel holding a hit owns it
    always_comb begin : token_pick
        any_hit = 1'b0;
        pick    = '0;
        for (int i = PIX_N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                any_hit = 1'b1;
                pick    = IDX_W'(i);
            end
        end
    end

    always_comb begin : next_state
        capture   = shutter_i && any_hit && (st_q.cnt < CNT_W'(DEPTH));
        last_word = (st_q.tx == TX_SEND) && (st_q.wcnt == WCNT_W'(NWORDS - 1));
        head_pad  = PAD_W'(st_q.mem[st_q.rptr]);

        take_o = '0;
        if (capture) begin
            take_o[pick] = 1'b1;
        end

        req_o     = (st_q.cnt != '0) && (st_q.tx == TX_IDLE);
        sending_o = (st_q.tx == TX_SEND);
        word_o    = sending_o ? head_pad[int'(st_q.wcnt)*BUS_W +: BUS_W] : '0;

        st_d = st_q;
        if (capture) begin
            st_d.mem[st_q.wptr] = {pick, data_i[int'(pick)*PIX_DW +: PIX_DW]};
            st_d.wptr           = ptr_next(st_q.wptr);
        end

        if (last_word) begin
            st_d.rptr = ptr_next(st_q.rptr);
            st_d.tx   = TX_IDLE;
            st_d.wcnt = '0;
        end else if (st_q.tx == TX_SEND) begin
            st_d.wcnt = st_q.wcnt + WCNT_W'(1);
        end else if (start_i) begin
            st_d.tx   = TX_SEND;
            st_d.wcnt = '0;
        end

        case ({capture, last_word})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/colro_col_arbiter.sv
module colro_col_arbiter #(
    parameter int N_SP   = 4,
    parameter int BUS_W  = 5,
    parameter int ADDR_W = 2
) (
    input  logic [N_SP-1:0]       req_i,
    input  logic [N_SP-1:0]       sending_i,
    input  logic                  eoc_full_i,
    input  logic [N_SP*BUS_W-1:0] words_i,
    output logic [N_SP-1:0]       start_o,
    output logic                  busy_o,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [BUS_W-1:0]      bus_o
);
    logic bus_busy;

    always_comb begin
        bus_busy = |sending_i;
        busy_o   = bus_busy;

        // grant only when the bus is free and the receiver has room
        start_o = '0;
        if (!bus_busy && !eoc_full_i) begin
            for (int s = N_SP - 1; s >= 0; s--) begin
                if (req_i[s]) begin
                    start_o    = '0;
                    start_o[s] = 1'b1;
                end
            end
        end

        addr_o = '0;
        bus_o  = '0;
        for (int s = 0; s < N_SP; s++) begin
            if (sending_i[s]) begin
                addr_o = ADDR_W'(s);
            end
            bus_o = bus_o | words_i[s*BUS_W +: BUS_W];
        end
    end

endmodule

// File: rtl/colro_eoc_buffer.sv
module colro_eoc_buffer
    import colro_pkg::*;
#(
    parameter int BUS_W  = 5,
    parameter int EV_W   = 15,
    parameter int ADDR_W = 2,
    parameter int DEPTH  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid_i,
    input  logic [BUS_W-1:0]       bus_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   rd_i,
    output logic                   full_o,
    output logic                   valid_o,
    output logic [ADDR_W+EV_W-1:0] event_o
);
    localparam int NWORDS = ceil_div(EV_W, BUS_W);
    localparam int PAD_W  = NWORDS * BUS_W;
    localparam int OUT_W  = ADDR_W + EV_W;
    localparam int PTR_W  = width_of(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PAD_W-1:0]            acc;
        logic [2:0]                  wcnt;
        logic [DEPTH-1:0][OUT_W-1:0] mem;
        logic [PTR_W-1:0]            wptr;
        logic [PTR_W-1:0]            rptr;
        logic [CNT_W-1:0]            cnt;
    } eoc_state_t;

    eoc_state_t st_d, st_q;

    logic [PAD_W-1:0] assembled;
    logic             last_word;
    logic             push;
    logic             pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        assembled = st_q.acc;
        assembled[int'(st_q.wcnt)*BUS_W +: BUS_W] = bus_i;

        last_word = bus_valid_i && (st_q.wcnt == 3'(NWORDS - 1));
        push      = last_word;
        pop       = rd_i && (st_q.cnt != '0);

        full_o  = (st_q.cnt == CNT_W'(DEPTH));
        valid_o = (st_q.cnt != '0);
        event_o = st_q.mem[st_q.rptr];

        st_d = st_q;
        if (bus_valid_i) begin
            st_d.acc  = assembled;
            st_d.wcnt = last_word ? 3'd0 : st_q.wcnt + 3'd1;
        end
        if (push) begin
            st_d.mem[st_q.wptr] = {addr_i, assembled[EV_W-1:0]};
            st_d.wptr           = ptr_next(st_q.wptr);
        end
        if (pop) begin
            st_d.rptr = ptr_next(st_q.rptr);
        end

        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sp_column_readout.sv
module sp_column_readout
    import colro_pkg::*;
#(
    parameter int NUM_SP     = 4,
    parameter int PIX_PER_SP = 8,
    parameter int PIX_DW     = 12,
    parameter int BUS_W      = 5,
    parameter int SP_DEPTH   = 2,
    parameter int EOC_DEPTH  = 4,
    localparam int SP_ADDR_W = width_of(NUM_SP),
    localparam int EV_W      = width_of(PIX_PER_SP) + PIX_DW,
    localparam int NPIX      = NUM_SP * PIX_PER_SP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shutter_i,
    input  logic [NPIX-1:0]           pix_hit_i,
    input  logic [NPIX*PIX_DW-1:0]    pix_data_i,
    output logic [NPIX-1:0]           pix_take_o,
    output logic [BUS_W-1:0]          col_data_o,
    output logic                      col_valid_o,
    output logic [SP_ADDR_W-1:0]      col_addr_o,
    output logic                      eoc_full_o,
    output logic                      eoc_valid_o,
    output logic [SP_ADDR_W+EV_W-1:0] eoc_event_o,
    input  logic                      eoc_rd_i
);
    logic [NUM_SP-1:0]       sp_req;
    logic [NUM_SP-1:0]       sp_sending;
    logic [NUM_SP-1:0]       sp_start;
    logic [NUM_SP*BUS_W-1:0] sp_words;

    for (genvar s = 0; s < NUM_SP; s++) begin : g_sp
        colro_sp_cell #(
            .PIX_N (PIX_PER_SP),
            .PIX_DW(PIX_DW),
            .BUS_W (BUS_W),
            .DEPTH (SP_DEPTH)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .shutter_i(shutter_i),
            .hit_i    (pix_hit_i[s*PIX_PER_SP +: PIX_PER_SP]),
            .data_i   (pix_data_i[s*PIX_PER_SP*PIX_DW +: PIX_PER_SP*PIX_DW]),
            .take_o   (pix_take_o[s*PIX_PER_SP +: PIX_PER_SP]),
            .start_i  (sp_start[s]),
            .req_o    (sp_req[s]),
            .sending_o(sp_sending[s]),
            .word_o   (sp_words[s*BUS_W +: BUS_W])
        );
    end

    colro_col_arbiter #(
        .N_SP  (NUM_SP),
        .BUS_W (BUS_W),
        .ADDR_W(SP_ADDR_W)
    ) u_arb (
        .req_i     (sp_req),
        .sending_i (sp_sending),
        .eoc_full_i(eoc_full_o),
        .words_i   (sp_words),
        .start_o   (sp_start),
        .busy_o    (col_valid_o),
        .addr_o    (col_addr_o),
        .bus_o     (col_data_o)
    );

    colro_eoc_buffer #(
        .BUS_W (BUS_W),
        .EV_W  (EV_W),
        .ADDR_W(SP_ADDR_W),
        .DEPTH (EOC_DEPTH)
    ) u_eoc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid_i(col_valid_o),
        .bus_i      (col_data_o),
        .addr_i     (col_addr_o),
        .rd_i       (eoc_rd_i),
        .full_o     (eoc_full_o),
        .valid_o    (eoc_valid_o),
        .event_o    (eoc_event_o)
    );

endmodule

// File: rtl/sp_column_readout_checker.sv
module sp_column_readout_checker
    import colro_pkg::*;
#(
    parameter int NUM_SP     = 4,
    parameter int PIX_PER_SP = 8,
    parameter int PIX_DW     = 12,
    parameter int BUS_W      = 5,
    parameter int ADDR_W     = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         shutter_i,
    input logic [NUM_SP*PIX_PER_SP-1:0] pix_hit_i,
    input logic [NUM_SP*PIX_PER_SP-1:0] pix_take_o,
    input logic                         col_valid_o,
    input logic [ADDR_W-1:0]            col_addr_o,
    input logic                         eoc_full_o,
    input logic [NUM_SP-1:0]            sending
);
    localparam int NWORDS = ceil_div(width_of(PIX_PER_SP) + PIX_DW, BUS_W);

    logic [3:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (col_valid_o) begin
            run_q <= run_q + 4'd1;
        end else begin
            run_q <= '0;
        end
    end

    assert_take_has_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_take_o & ~pix_hit_i) == '0);

    for (genvar s = 0; s < NUM_SP; s++) begin : g_take
        assert_take_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pix_take_o[s*PIX_PER_SP +: PIX_PER_SP]));
    end

    assert_take_shutter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|pix_take_o) |-> shutter_i);

    assert_single_sender_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sending));

    assert_whole_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && (run_q < 4'(NWORDS - 1))) |=> (col_valid_o && $stable(col_addr_o)));

    assert_gap_after_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && (run_q == 4'(NWORDS - 1))) |=> !col_valid_o);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o |-> !eoc_full_o);

    assert_start_when_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid_o) |-> !$past(eoc_full_o));

endmodule

bind sp_column_readout sp_column_readout_checker #(
    .NUM_SP    (NUM_SP),
    .PIX_PER_SP(PIX_PER_SP),
    .PIX_DW    (PIX_DW),
    .BUS_W     (BUS_W),
    .ADDR_W    (SP_ADDR_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutter_i  (shutter_i),
    .pix_hit_i  (pix_hit_i),
    .pix_take_o (pix_take_o),
    .col_valid_o(col_valid_o),
    .col_addr_o (col_addr_o),
    .eoc_full_o (eoc_full_o),
    .sending    (sp_sending)
);

// File: tb/sp_column_readout_tb.sv
module sp_column_readout_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSP  = 4;
    localparam int NPX  = 8;
    localparam int DW   = 12;
    localparam int BW   = 5;
    localparam int SPD  = 2;
    localparam int ED   = 4;
    localparam int EVW  = 15;
    localparam int NW   = 3;
    localparam int NPIX = NSP * NPX;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shutter = 1'b0;
    logic rd = 1'b0;
    logic [NPIX-1:0]    hit = '0;
    logic [NPIX*DW-1:0] pdata = '0;

    logic [NPIX-1:0] take;
    logic [BW-1:0]   col_data;
    logic            col_valid;
    logic [1:0]      col_addr;
    logic            eoc_full;
    logic            eoc_valid;
    logic [16:0]     eoc_event;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sp_column_readout u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .shutter_i  (shutter),
        .pix_hit_i  (hit),
        .pix_data_i (pdata),
        .pix_take_o (take),
        .col_data_o (col_data),
        .col_valid_o(col_valid),
        .col_addr_o (col_addr),
        .eoc_full_o (eoc_full),
        .eoc_valid_o(eoc_valid),
        .eoc_event_o(eoc_event),
        .eoc_rd_i   (rd)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int spq[NSP][$];
    bit snd[NSP];
    int wix[NSP];
    int eq[$];
    logic [NPIX-1:0] m_take;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ev(input int s, input int p, input int d);
        return (s << EVW) | (p << DW) | d;
    endfunction

    task automatic set_hit(input int s, input int p, input int d);
        hit[s*NPX+p] = 1'b1;
        pdata[(s*NPX+p)*DW +: DW] = DW'(d);
    endtask

    task automatic compare_model(input string tag);
        logic m_valid;
        logic [BW-1:0] m_data;
        int m_addr;
        m_take = '0;
        for (int s = 0; s < NSP; s++) begin
            if (shutter && spq[s].size() < SPD) begin
                for (int p = 0; p < NPX; p++) begin
                    if (hit[s*NPX+p]) begin
                        m_take[s*NPX+p] = 1'b1;
                        break;
                    end
                end
            end
        end
        m_valid = 1'b0;
        m_data = '0;
        m_addr = 0;
        for (int s = 0; s < NSP; s++) begin
            if (snd[s]) begin
                m_valid = 1'b1;
                m_addr = s;
                m_data = BW'((spq[s][0] >> (wix[s] * BW)) & 31);
            end
        end
        chk({tag, " R1 R2 take"}, 32'(take), 32'(m_take));
        chk({tag, " R4 present"}, 32'(col_valid), 32'(m_valid));
        chk({tag, " R4 word"}, 32'(col_data), 32'(m_data));
        if (m_valid) chk({tag, " R3 sender"}, 32'(col_addr), 32'(m_addr));
        chk({tag, " R5 full"}, 32'(eoc_full), 32'(eq.size() == ED));
        chk({tag, " R6 valid"}, 32'(eoc_valid), 32'(eq.size() > 0));
        if (eq.size() > 0) chk({tag, " R6 event"}, 32'(eoc_event), 32'(eq[0]));
    endtask

    task automatic model_step();
        bit busy;
        bit full;
        bit req[NSP];
        busy = 0;
        for (int s = 0; s < NSP; s++) busy |= snd[s];
        full = (eq.size() == ED);
        for (int s = 0; s < NSP; s++) req[s] = (spq[s].size() > 0) && !snd[s];
        if (rd && eq.size() > 0) void'(eq.pop_front());
        for (int s = 0; s < NSP; s++) begin
            if (snd[s]) begin
                if (wix[s] == NW - 1) begin
                    eq.push_back((s << EVW) | spq[s][0]);
                    void'(spq[s].pop_front());
                    snd[s] = 0;
                end else begin
                    wix[s]++;
                end
            end
        end
        for (int i = 0; i < NPIX; i++) begin
            if (m_take[i]) spq[i / NPX].push_back(((i % NPX) << DW) | int'(pdata[i*DW +: DW]));
        end
        if (!busy && !full) begin
            for (int s = 0; s < NSP; s++) begin
                if (req[s]) begin
                    snd[s] = 1;
                    wix[s] = 0;
                    break;
                end
            end
        end
    endtask

    task automatic cycle(input string tag);
        logic [NPIX-1:0] clr;
        #1;
        compare_model(tag);
        model_step();
        clr = m_take;
        @(posedge clk);
        @(negedge clk);
        hit = hit & ~clr;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    task automatic read_expect(input int exp, input string tag);
        #1;
        chk({tag, " head valid"}, 32'(eoc_valid), 32'd1);
        chk({tag, " head event"}, 32'(eoc_event), 32'(exp));
        rd = 1'b1;
        cycle(tag);
        rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R7 reset take", 32'(take), 32'd0);
        chk("R7 reset present", 32'(col_valid), 32'd0);
        chk("R7 reset full", 32'(eoc_full), 32'd0);
        chk("R7 reset valid", 32'(eoc_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        shutter = 1'b1;

        // single event, words and reassembly
        set_hit(0, 3, 'hABC);
        run(7, "R4 single");
        read_expect(ev(0, 3, 'hABC), "R6 single");

        // token order inside one super pixel
        set_hit(1, 6, 'h111);
        set_hit(1, 2, 'h222);
        set_hit(1, 5, 'h333);
        run(20, "R1 order");
        read_expect(ev(1, 2, 'h222), "R1 first");
        read_expect(ev(1, 5, 'h333), "R1 second");
        read_expect(ev(1, 6, 'h111), "R1 third");

        // shutter gating
        shutter = 1'b0;
        set_hit(2, 0, 'h5A5);
        run(5, "R2 closed");
        #1;
        chk("R2 no take while closed", 32'(take), 32'd0);
        chk("R2 nothing stored while closed", 32'(eoc_valid), 32'd0);
        shutter = 1'b1;
        run(8, "R2 open");
        read_expect(ev(2, 0, 'h5A5), "R2 taken after open");

        // column priority
        set_hit(3, 1, 'h0F0);
        set_hit(1, 4, 'h00F);
        run(12, "R3 priority");
        read_expect(ev(1, 4, 'h00F), "R3 lower index first");
        read_expect(ev(3, 1, 'h0F0), "R3 then higher index");

        // capture order beats pixel index
        set_hit(0, 5, 'h765);
        cycle("R8 first hit");
        set_hit(0, 1, 'h123);
        run(14, "R8 order");
        read_expect(ev(0, 5, 'h765), "R8 earlier capture");
        read_expect(ev(0, 1, 'h123), "R8 later capture");

        // full end-of-column buffer stalls the bus
        set_hit(0, 0, 'h001);
        set_hit(0, 1, 'h002);
        set_hit(1, 0, 'h003);
        set_hit(2, 0, 'h004);
        set_hit(2, 1, 'h005);
        set_hit(3, 0, 'h006);
        run(40, "R5 fill");
        #1;
        chk("R5 buffer full", 32'(eoc_full), 32'd1);
        chk("R5 bus idle while full", 32'(col_valid), 32'd0);
        read_expect(ev(0, 0, 'h001), "R5 first out");
        run(8, "R5 resume");
        read_expect(ev(0, 1, 'h002), "R5 second out");
        read_expect(ev(1, 0, 'h003), "R5 third out");
        run(10, "R5 drain");
        read_expect(ev(2, 0, 'h004), "R5 fourth out");
        read_expect(ev(2, 1, 'h005), "R5 fifth out");
        read_expect(ev(3, 0, 'h006), "R5 sixth out");
        #1;
        chk("R6 empty after drain", 32'(eoc_valid), 32'd0);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 3 == 0) begin
                int s = int'($urandom % NSP);
                int p = int'($urandom % NPX);
                if (!hit[s*NPX+p]) set_hit(s, p, int'($urandom % 4096));
            end
            shutter = ($urandom % 16) != 0;
            rd = ($urandom % 2) != 0;
            cycle("R1 R3 R8 random");
        end
        shutter = 1'b0;
        hit = '0;
        rd = 1'b1;
        run(120, "R6 final drain");
        rd = 1'b0;
        #1;
        chk("R6 drained", 32'(eoc_valid), 32'd0);
        chk("R8 model queues empty", 32'(spq[0].size() + spq[1].size() + spq[2].size() + spq[3].size()), 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule